// File: doc/BRIEF.md
# Per-Frame DCS Short-Write Replay Sequencer

This block keeps a small table of display command pairs. Each pair is a command index byte plus one parameter byte. At every start of a video frame it plays the table back as a stream of four-byte short packets toward a link layer. Each packet carries the one-parameter short-write data type 0x15, the index, the value and an error-correcting byte. The block works out that byte on the fly from the first three bytes.

Software loads pairs through a slot-addressed write port. It sets the enable and the number of bytes to send per frame through a control write. After that the same sequence goes out on every frame with no further action. The output is a byte-wide valid/ready stream. A busy output marks a sequence in progress. Table writes that land during a sequence are deferred, so a packet is never built from a half-updated entry.

Top module: `dcs_frame_replay`

## Requirements
- R1: Each packet is sent as four bytes, lowest first: data type 0x15, then the slot's index byte, then its value byte, then the check byte. Packets follow slot order 0, 1, 2 and so on.
- R2: The check byte is the XOR, over every set bit i of the 24-bit header {value, index, 0x15}, of a fixed 6-bit mask for bit i. Bit 0 is the data type's bit 0. The two top bits of the check byte are always 0.
- R3: There are 8 slots, numbered 0..7 on a 4-bit slot field. A write to slot 8..15 stores nothing and sets the sticky `err` output. Any control write clears `err` in the next cycle, unless a bad slot write arrives in the same cycle.
- R4: A `sof` pulse while enabled, idle and with byte count N > 0 raises `busy` and `out_valid` in the next cycle. Exactly N bytes are then sent and `busy` falls after the last handshake. A count above 32 is clamped to 32.
- R5: With no further writes, every later `sof` replays an identical byte sequence.
- R6: A `sof` is ignored while the enable is 0 or the byte count is 0.
- R7: A `sof` that arrives while `busy` is 1 is ignored: the running sequence keeps its length, and no second sequence follows.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged in the next cycle.
- R9: A valid table write while `busy` is 1 is held and applied once `busy` has fallen, so the current sequence uses the old contents. Only one write is held: a later held write replaces the earlier one. A write while idle takes effect in the next cycle.
- R10: The byte count is captured when a sequence starts. A control write during a sequence affects only later frames.
- R11: After reset, `busy`, `out_valid` and `err` are 0, the block is disabled, and every slot holds index 0 and value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse |
| cmd_wr | input | 1 | Table write strobe |
| cmd_slot | input | 4 | Target slot (8..15 invalid) |
| cmd_index | input | 8 | Command index byte |
| cmd_value | input | 8 | Parameter byte |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable for per-frame replay |
| ctl_bytes | input | 6 | Bytes sent per frame (clamped to 32) |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_ready | input | 1 | Stream byte accepted |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Sticky invalid-slot flag |

## Verification
Four kinds of table contents are sent through the stream and compared byte by byte with a parity-column model of the check byte. These are an all-zero table straight after reset, two fixed headers with hand-worked check bytes, and two rounds of random index and value bytes. The zero and fixed headers expose a wrong mask for single low-order bits. The random rounds expose wrong masks on the index and value bits and errors in lane order. Short, clamped and stalled frames separate errors in length counting from errors in back-pressure. Writes, control changes and frame pulses injected mid-sequence tell apart the deferral, snapshot and ignore rules.

// File: rtl/dcs_frame_replay.sv
module dcs_frame_replay #(
  parameter int NSLOT = 8,
  parameter logic [7:0] DTYPE = 8'h15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_slot,
  input  logic [7:0] cmd_index,
  input  logic [7:0] cmd_value,
  input  logic       ctl_wr,
  input  logic       ctl_en,
  input  logic [5:0] ctl_bytes,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       busy,
  output logic       err
);
  localparam int AW   = $clog2(NSLOT);
  localparam int MAXB = 4 * NSLOT;
  localparam int CW   = $clog2(MAXB + 1);
  localparam logic [3:0]    NS   = 4'(NSLOT);
  localparam logic [CW-1:0] MAXC = CW'(MAXB);

  function automatic logic [5:0] ecc_mask(input int i);
    case (i)
      0: return 6'h07;  1: return 6'h0B;  2: return 6'h0D;  3: return 6'h0E;
      4: return 6'h13;  5: return 6'h15;  6: return 6'h16;  7: return 6'h19;
      8: return 6'h1A;  9: return 6'h1C; 10: return 6'h23; 11: return 6'h25;
     12: return 6'h26; 13: return 6'h29; 14: return 6'h2A; 15: return 6'h2C;
     16: return 6'h31; 17: return 6'h32; 18: return 6'h34; 19: return 6'h38;
     20: return 6'h1F; 21: return 6'h2F; 22: return 6'h37; default: return 6'h3B;
    endcase
  endfunction

  function automatic logic [7:0] hdr_ecc(input logic [23:0] h);
    logic [5:0] e;
    e = '0;
    for (int i = 0; i < 24; i++)
      if (h[i]) e = e ^ ecc_mask(i);
    return {2'b00, e};
  endfunction

  logic [7:0]    idx_q [NSLOT];
  logic [7:0]    val_q [NSLOT];
  logic          en_q, busy_q, err_q, hold_v;
  logic [CW-1:0] cnt_q, len_q, ptr_q;
  logic [AW-1:0] hold_slot;
  logic [7:0]    hold_idx, hold_val;

  wire           slot_ok = cmd_wr && (cmd_slot < NS);
  wire [CW-1:0]  req_len = ({{(CW-6){1'b0}}, ctl_bytes} > MAXC) ? MAXC
                                                               : CW'(ctl_bytes);
  wire           start   = sof && !busy_q && en_q && (cnt_q != '0);
  wire           fire    = busy_q && out_ready;
  wire           last    = fire && (ptr_q == len_q - CW'(1));
  wire [1:0]     lane    = ptr_q[1:0];
  wire [AW-1:0]  cur     = ptr_q[AW+1:2];
  wire [23:0]    hdr     = {val_q[cur], idx_q[cur], DTYPE};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q  <= ctl_en;
        cnt_q <= req_len;
      end
      if (cmd_wr && !slot_ok) err_q <= 1'b1;
      else if (ctl_wr)        err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
      len_q  <= cnt_q;
    end else if (fire) begin
      ptr_q <= ptr_q + CW'(1);
      if (last) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_slot <= '0;
      hold_idx  <= '0;
      hold_val  <= '0;
    end else if (busy_q && slot_ok) begin
      hold_v    <= 1'b1;
      hold_slot <= cmd_slot[AW-1:0];
      hold_idx  <= cmd_index;
      hold_val  <= cmd_value;
    end else if (!busy_q) begin
      hold_v <= 1'b0;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_q[s] <= '0;
        val_q[s] <= '0;
      end else if (!busy_q) begin
        if (slot_ok && cmd_slot[AW-1:0] == AW'(s)) begin
          idx_q[s] <= cmd_index;
          val_q[s] <= cmd_value;
        end else if (hold_v && hold_slot == AW'(s)) begin
          idx_q[s] <= hold_idx;
          val_q[s] <= hold_val;
        end
      end
    end
  end

  always_comb begin
    case (lane)
      2'd0:    out_data = hdr[7:0];
      2'd1:    out_data = hdr[15:8];
      2'd2:    out_data = hdr[23:16];
      default: out_data = hdr_ecc(hdr);
    endcase
  end

  assign out_valid = busy_q;
  assign busy      = busy_q;
  assign err       = err_q;
endmodule

module dcs_frame_replay_chk #(
  parameter int NSLOT = 8,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sof,
  input logic          cmd_wr,
  input logic [3:0]    cmd_slot,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          out_ready,
  input logic          busy,
  input logic          err,
  input logic [1:0]    lane,
  input logic          en,
  input logic [CW-1:0] cnt
);
  p_dtype_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && lane == 2'd0 |-> out_data == 8'h15);
  p_ecc_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && lane == 2'd3 |-> out_data[7:6] == 2'b00);
  p_bad_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_slot >= 4'(NSLOT) |=> err);
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof && !busy && en && cnt != '0 |=> busy && out_valid);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (!en || cnt == '0) |=> !busy);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind dcs_frame_replay dcs_frame_replay_chk #(.NSLOT(NSLOT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .cmd_wr(cmd_wr), .cmd_slot(cmd_slot),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .busy(busy), .err(err), .lane(lane), .en(en_q), .cnt(cnt_q)
);

// File: tb/dcs_frame_replay_tb.sv
module dcs_frame_replay_tb;
  logic       clk = 1'b0, rst_n = 1'b0, sof = 1'b0;
  logic       cmd_wr = 1'b0, ctl_wr = 1'b0, ctl_en = 1'b0, out_ready = 1'b1;
  logic [3:0] cmd_slot = '0;
  logic [7:0] cmd_index = '0, cmd_value = '0;
  logic [5:0] ctl_bytes = '0;
  logic       out_valid, busy, err;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  dcs_frame_replay u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .cmd_wr(cmd_wr), .cmd_slot(cmd_slot),
    .cmd_index(cmd_index), .cmd_value(cmd_value), .ctl_wr(ctl_wr),
    .ctl_en(ctl_en), .ctl_bytes(ctl_bytes), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .busy(busy), .err(err)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] m_idx [8];
  logic [7:0] m_val [8];
  logic [7:0] got [64];
  int got_n;
  logic [23:0] col [6];
  logic [5:0] msk [24] = '{6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
                           6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
                           6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_ecc(input logic [23:0] h);
    logic [7:0] e = '0;
    for (int j = 0; j < 6; j++) e[j] = ^(h & col[j]);
    return e;
  endfunction

  function automatic logic [7:0] exp_byte(input int p);
    logic [23:0] h = {m_val[p/4], m_idx[p/4], 8'h15};
    case (p % 4)
      0: return h[7:0];
      1: return h[15:8];
      2: return h[23:16];
      default: return ref_ecc(h);
    endcase
  endfunction

  task automatic wr_cmd(input logic [3:0] s, input logic [7:0] i, input logic [7:0] v);
    @(negedge clk);
    cmd_wr = 1; cmd_slot = s; cmd_index = i; cmd_value = v;
    @(negedge clk);
    cmd_wr = 0;
    if (s < 8) begin m_idx[s] = i; m_val[s] = v; end
  endtask

  task automatic wr_ctl(input logic en, input logic [5:0] b);
    @(negedge clk);
    ctl_wr = 1; ctl_en = en; ctl_bytes = b;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  // kind: 0 none, 1 sof, 2 two table writes (slot 7 then slot 6), 3 control write
  task automatic frame(input bit stall, input int kind, input int at, input string tag);
    int cyc = 0;
    bit pv = 0;
    logic [7:0] pd = '0;
    got_n = 0;
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
    chk(busy === 1'b1 && out_valid === 1'b1, {tag, " R4 start"}, busy, 1);
    while (busy && cyc < 400) begin
      out_ready = stall ? (cyc % 3 == 2) : 1'b1;
      if (pv) chk(out_valid === 1'b1 && out_data === pd, {tag, " R8 stall hold"}, out_data, pd);
      pv = out_valid && !out_ready;
      pd = out_data;
      if (out_valid && out_ready) begin got[got_n] = out_data; got_n++; end
      if (cyc == at && kind == 1) sof = 1;
      if (cyc == at && kind == 2) begin cmd_wr = 1; cmd_slot = 7; cmd_index = 8'hAA; cmd_value = 8'h55; end
      if (cyc == at + 1 && kind == 2) begin cmd_wr = 1; cmd_slot = 6; cmd_index = 8'hBB; cmd_value = 8'h66; end
      if (cyc == at && kind == 3) begin ctl_wr = 1; ctl_en = 1; ctl_bytes = 6'd8; end
      @(negedge clk);
      sof = 0; cmd_wr = 0; ctl_wr = 0;
      cyc++;
    end
    out_ready = 1;
  endtask

  task automatic cmp(input int n, input string tag);
    chk(got_n == n, {tag, " byte count"}, got_n, n);
    for (int p = 0; p < n && p < got_n; p++)
      chk(got[p] === exp_byte(p), {tag, " byte"}, got[p], exp_byte(p));
  endtask

  task automatic t_reset;
    chk(busy === 0 && out_valid === 0 && err === 0, "R11 reset outputs", {busy, out_valid, err}, 0);
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
    chk(busy === 0, "R11 disabled after reset", busy, 0);
    wr_ctl(1, 6'd32);
    frame(0, 0, -1, "R11 zero table");
    cmp(32, "R11 R1 zero table");
    chk(got[3] === 8'h19, "R2 ecc of 0x000015", got[3], 8'h19);
  endtask

  task automatic t_known;
    wr_cmd(0, 8'h00, 8'h00);
    wr_cmd(1, 8'h29, 8'h00);
    frame(0, 0, -1, "R2 known");
    chk(got[7] === 8'h0F, "R2 ecc of 0x002915", got[7], 8'h0F);
    chk(got[5] === 8'h29, "R1 index lane", got[5], 8'h29);
    cmp(32, "R1 known");
  endtask

  task automatic t_random;
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 8; s++) wr_cmd(4'(s), 8'($urandom), 8'($urandom));
      frame(0, 0, -1, "R2 random");
      cmp(32, "R2 R1 random");
    end
  endtask

  task automatic t_length;
    wr_ctl(1, 6'd6);
    frame(0, 0, -1, "R4 short");
    cmp(6, "R4 six bytes");
    wr_ctl(1, 6'd40);
    frame(0, 0, -1, "R4 clamp");
    cmp(32, "R4 clamp to 32");
  endtask

  task automatic t_repeat;
    logic [7:0] first [32];
    frame(0, 0, -1, "R5 f1");
    for (int p = 0; p < 32; p++) first[p] = got[p];
    frame(0, 0, -1, "R5 f2");
    for (int p = 0; p < 32; p++) chk(got[p] === first[p], "R5 replay identical", got[p], first[p]);
  endtask

  task automatic t_off;
    wr_ctl(0, 6'd32);
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
    chk(busy === 0 && out_valid === 0, "R6 disabled sof ignored", busy, 0);
    wr_ctl(1, 6'd0);
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
    chk(busy === 0 && out_valid === 0, "R6 zero count sof ignored", busy, 0);
    wr_ctl(1, 6'd32);
  endtask

  task automatic t_sof_busy;
    frame(0, 1, 4, "R7");
    cmp(32, "R7 length kept");
    repeat (3) @(negedge clk);
    chk(busy === 0, "R7 no second sequence", busy, 0);
  endtask

  task automatic t_stall;
    frame(1, 0, -1, "R8");
    cmp(32, "R8 stalled stream");
  endtask

  task automatic t_err;
    logic [7:0] o_i = m_idx[0];
    wr_cmd(4'd8, 8'hEE, 8'hDD);
    chk(err === 1, "R3 slot 8 sets err", err, 1);
    wr_cmd(4'd15, 8'hEE, 8'hDD);
    chk(err === 1, "R3 err sticky", err, 1);
    frame(0, 0, -1, "R3");
    chk(got[1] === o_i, "R3 slot 0 untouched", got[1], o_i);
    cmp(32, "R3 table untouched");
    wr_ctl(1, 6'd32);
    chk(err === 0, "R3 ctl write clears err", err, 0);
  endtask

  task automatic t_hold;
    frame(0, 2, 2, "R9");
    cmp(32, "R9 old contents during busy");
    m_idx[6] = 8'hBB; m_val[6] = 8'h66;
    frame(0, 0, -1, "R9 next");
    cmp(32, "R9 last held write applied");
    chk(got[29] !== 8'hAA, "R9 replaced held write dropped", got[29], m_idx[7]);
  endtask

  task automatic t_snap;
    frame(0, 3, 3, "R10");
    cmp(32, "R10 running length kept");
    frame(0, 0, -1, "R10 next");
    cmp(8, "R10 new length next frame");
    wr_ctl(1, 6'd32);
  endtask

  initial begin
    for (int j = 0; j < 6; j++) col[j] = '0;
    for (int i = 0; i < 24; i++)
      for (int j = 0; j < 6; j++) col[j][i] = msk[i][j];
    for (int s = 0; s < 8; s++) begin m_idx[s] = 0; m_val[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_known;
    t_random;
    t_length;
    t_repeat;
    t_off;
    t_sof_busy;
    t_stall;
    t_err;
    t_hold;
    t_snap;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule